// File: doc/BRIEF.md
# Flash Read Error Response Filter

This block sits on the return path from a flash array to the bus masters that read it. Each returned beat comes with three error flags from the upstream ECC and control logic: an uncorrectable ECC error, an internal fault of the flash interface, and a corrected single-bit error. Each beat is also tagged with the class of the master that asked for it, either CPU/debug or non-CPU. The block decides, per beat, whether the master sees a bus-error response, and whether the data must be kept out of caches and prefetch buffers. The data itself is always passed through.

Two interfaces are handled side by side. They are called main and work here, and each has its own silent-mode control input. With silent mode on, CPU/debug masters receive errored data without a bus error. Non-CPU masters always receive a bus error on a non-recoverable error. Internal interface faults caused by CPU masters are logged in sticky status bits, one per CPU master per interface, and software clears them with write-one-to-clear pulses. Every beat that carries a flag also raises a one-cycle fault event with a 2-bit code, for a system fault collector.

Top module: `frf_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is 0 after that edge (responses, data, fault event, status bits).
- R2: A beat accepted with `rd_valid[i]=1` at edge N appears at edge N+1 with `rsp_valid[i]=1` and `rsp_data` equal to the input data, whatever the error flags are. When `rd_valid[i]=0`, `rsp_data[i]` is 0.
- R3: A non-recoverable beat (uncorrectable ECC or internal fault) from a non-CPU master (`rd_cpu[i]=0`) gives `rsp_berr[i]=1`, whatever `silent_en[i]` is.
- R4: A non-recoverable beat from a CPU/debug master (`rd_cpu[i]=1`) with `silent_en[i]=0` gives `rsp_berr[i]=1`.
- R5: A beat from a CPU/debug master with `silent_en[i]=1` gives `rsp_berr[i]=0`. A beat with no non-recoverable error never gives a bus error.
- R6: `rsp_nocache[i]` is 1 exactly for non-recoverable beats, for both master classes and both silent settings. A corrected-only beat is cacheable.
- R7: `flt_valid[i]` is 1 for one cycle for each valid beat that carries any flag. `flt_code[i]` uses internal=1, uncorrectable=2, corrected=3, with that priority, and is 0 when `flt_valid[i]` is 0.
- R8: Status bit `sts_int[i*NCPU+k]` is set one edge after a valid beat on interface i from a CPU master with `rd_cpu_id=k` that carries the internal-fault flag. Uncorrectable ECC errors, corrected errors, non-CPU masters and ids of NCPU or above do not set it.
- R9: Status bits are sticky. A 1 on `sts_clr[j]` clears bit j at the next edge. If a set and a clear hit the same bit in the same cycle, the set wins.
- R10: The two interfaces are independent. One interface's silent input has no effect on the other interface's responses.
- R11: Error flags on a beat with `rd_valid[i]=0` produce no response, no fault event and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| silent_en | input | NIF | Silent-mode control per interface |
| rd_valid | input | NIF | Read beat valid per interface |
| rd_data | input | NIF*DW | Read beat data, interface i at bits [i*DW +: DW] |
| rd_ecc_unc | input | NIF | Uncorrectable ECC error flag |
| rd_int_err | input | NIF | Internal interface fault flag |
| rd_ecc_cor | input | NIF | Corrected ECC error flag |
| rd_cpu | input | NIF | Master class: 1 CPU/debug, 0 non-CPU |
| rd_cpu_id | input | NIF*IDW | CPU master index |
| sts_clr | input | NIF*NCPU | Write-one-to-clear pulses for status bits |
| rsp_valid | output | NIF | Registered response valid |
| rsp_data | output | NIF*DW | Registered response data |
| rsp_berr | output | NIF | Bus-error response |
| rsp_nocache | output | NIF | Data must not be cached or buffered |
| flt_valid | output | NIF | One-cycle fault event |
| flt_code | output | NIF*2 | Fault code of the event |
| sts_int | output | NIF*NCPU | Sticky internal-fault status per CPU master per interface |

## Verification
A wrong response register shows at the ports one cycle after the offending beat: the error flag or the cacheability flag is wrong in the same cycle as the data it belongs to, so every clock comparison against the reference model catches it at once. A stuck or wrongly set status bit can stay hidden until a clear pulse or a later internal fault hits that bit, so the bench compares the whole status vector on every cycle and drives random clear pulses. A swap between interfaces or master indices shows up as soon as traffic on one interface changes another interface's bits.

// File: rtl/frf_pkg.sv
// Package: shared fault code encoding and beat classification for the
// flash read error response filter.
package frf_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_INTERNAL = 2'd1,
        FLT_ECC_UNC  = 2'd2,
        FLT_ECC_COR  = 2'd3
    } flt_code_e;

    // Pick the reported fault code: internal > uncorrectable > corrected.
    function automatic flt_code_e classify(input logic int_err,
                                           input logic ecc_unc,
                                           input logic ecc_cor);
        if (int_err)      return FLT_INTERNAL;
        else if (ecc_unc) return FLT_ECC_UNC;
        else if (ecc_cor) return FLT_ECC_COR;
        else              return FLT_NONE;
    endfunction

endpackage

// File: rtl/frf_resp_stage.sv
// Module: frf_resp_stage
// Registers one interface's response. It decides on the bus error and the
// no-cache indication and produces the fault event.
// Assumes: the error flags are only meaningful when in_valid is 1. The
// silent control is sampled in the same cycle as the beat.
module frf_resp_stage
    import frf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          silent,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_unc,
    input  logic          in_int,
    input  logic          in_cor,
    input  logic          in_cpu,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_berr,
    output logic          out_nocache,
    output logic          flt_valid,
    output logic [1:0]    flt_code
);

    logic      nonrec;
    logic      any_flag;
    flt_code_e code_d;
    flt_code_e code_q;

    // Combine the flags of the incoming beat.
    always_comb begin
        nonrec   = in_valid && (in_unc || in_int);
        any_flag = in_valid && (in_unc || in_int || in_cor);
        code_d   = in_valid ? classify(in_int, in_unc, in_cor) : FLT_NONE;
    end

    // Response register: data, error signalling and fault event move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_berr    <= 1'b0;
            out_nocache <= 1'b0;
            flt_valid   <= 1'b0;
            code_q      <= FLT_NONE;
        end else begin
            out_valid   <= in_valid;
            out_data    <= in_valid ? in_data : '0;
            out_berr    <= nonrec && (!in_cpu || !silent);
            out_nocache <= nonrec;
            flt_valid   <= any_flag;
            code_q      <= code_d;
        end
    end

    assign flt_code = code_q;

    // R2: data comes out one cycle after it is accepted.
    p_data_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_data == $past(in_data)));

    // R3: non-CPU masters always see the error.
    p_noncpu_berr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_cpu && (in_unc || in_int)) |=> out_berr);

    // R4: CPU masters see the error when silent mode is off.
    p_cpu_berr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cpu && !silent && (in_unc || in_int)) |=> out_berr);

    // R5: silent mode hides the error from CPU masters.
    p_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cpu && silent) |=> !out_berr);

    // R6: a bus error always comes with the no-cache flag.
    p_berr_nocache_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_berr |-> out_nocache);

    // R7: an event carries a code, and no event means code 0.
    p_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid == (flt_code != 2'd0));

    // R11: an idle beat produces nothing.
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !flt_valid && !out_berr && !out_nocache));

endmodule

// File: rtl/frf_status_bank.sv
// Module: frf_status_bank
// Sticky internal-fault status bits, one per CPU master, for one interface.
// Assumes: log_en already covers valid, CPU class and the internal-fault flag.
// Ids of NCPU or above set no bit. On the same bit in the same cycle, a set
// wins over a clear.
module frf_status_bank #(
    parameter int NCPU = 3,
    parameter int IDW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            log_en,
    input  logic [IDW-1:0]  log_id,
    input  logic [NCPU-1:0] clr,
    output logic [NCPU-1:0] sts
);

    for (genvar k = 0; k < NCPU; k++) begin : g_bit
        logic hit;

        // Decode whether this master's bit is set by the current beat.
        always_comb hit = log_en && (log_id == IDW'(k));

        // Sticky bit with write-one-to-clear, where a set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)      sts[k] <= 1'b0;
            else if (hit)    sts[k] <= 1'b1;
            else if (clr[k]) sts[k] <= 1'b0;
        end

        // R9: the bit holds without a clear.
        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[k] && !clr[k]) |=> sts[k]);

        // R9: a clear takes effect at the next edge unless a set is pending.
        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !hit) |=> !sts[k]);

        // R8: the bit only rises after a logged internal fault from master k.
        p_only_log_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!sts[k] && !(log_en && log_id == IDW'(k))) |=> !sts[k]);
    end

endmodule

// File: rtl/frf_top.sv
// Module: frf_top
// Flash read error response filter for NIF interfaces. Each interface gets
// a response stage and a status bank with one bit per CPU master.
// Assumes: interface i uses slice i of every packed vector. Status bit
// i*NCPU+k belongs to CPU master k on interface i.
module frf_top #(
    parameter int NIF  = 2,
    parameter int NCPU = 3,
    parameter int DW   = 32,
    parameter int IDW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NIF-1:0]      silent_en,
    input  logic [NIF-1:0]      rd_valid,
    input  logic [NIF*DW-1:0]   rd_data,
    input  logic [NIF-1:0]      rd_ecc_unc,
    input  logic [NIF-1:0]      rd_int_err,
    input  logic [NIF-1:0]      rd_ecc_cor,
    input  logic [NIF-1:0]      rd_cpu,
    input  logic [NIF*IDW-1:0]  rd_cpu_id,
    input  logic [NIF*NCPU-1:0] sts_clr,
    output logic [NIF-1:0]      rsp_valid,
    output logic [NIF*DW-1:0]   rsp_data,
    output logic [NIF-1:0]      rsp_berr,
    output logic [NIF-1:0]      rsp_nocache,
    output logic [NIF-1:0]      flt_valid,
    output logic [NIF*2-1:0]    flt_code,
    output logic [NIF*NCPU-1:0] sts_int
);

    for (genvar i = 0; i < NIF; i++) begin : g_if
        logic log_en;

        // Only internal faults from CPU masters are logged.
        always_comb log_en = rd_valid[i] && rd_cpu[i] && rd_int_err[i];

        frf_resp_stage #(.DW(DW)) u_resp (
            .clk        (clk),
            .rst_n      (rst_n),
            .silent     (silent_en[i]),
            .in_valid   (rd_valid[i]),
            .in_data    (rd_data[i*DW +: DW]),
            .in_unc     (rd_ecc_unc[i]),
            .in_int     (rd_int_err[i]),
            .in_cor     (rd_ecc_cor[i]),
            .in_cpu     (rd_cpu[i]),
            .out_valid  (rsp_valid[i]),
            .out_data   (rsp_data[i*DW +: DW]),
            .out_berr   (rsp_berr[i]),
            .out_nocache(rsp_nocache[i]),
            .flt_valid  (flt_valid[i]),
            .flt_code   (flt_code[i*2 +: 2])
        );

        frf_status_bank #(.NCPU(NCPU), .IDW(IDW)) u_sts (
            .clk   (clk),
            .rst_n (rst_n),
            .log_en(log_en),
            .log_id(rd_cpu_id[i*IDW +: IDW]),
            .clr   (sts_clr[i*NCPU +: NCPU]),
            .sts   (sts_int[i*NCPU +: NCPU])
        );

        // R8: an uncorrectable ECC error without an internal fault is not logged.
        p_ecc_unlogged_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid[i] && rd_ecc_unc[i] && !rd_int_err[i] &&
             sts_int[i*NCPU +: NCPU] == '0) |=> (sts_int[i*NCPU +: NCPU] == '0));
    end

endmodule

// File: tb/frf_top_test.sv
// Bench: a behavioural reference model updated on each rising edge, compared
// with all outputs at every falling edge.
module frf_top_test;

    localparam int NIF  = 2;
    localparam int NCPU = 3;
    localparam int DW   = 32;
    localparam int IDW  = 2;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NIF-1:0]      silent_en;
    logic [NIF-1:0]      rd_valid;
    logic [NIF*DW-1:0]   rd_data;
    logic [NIF-1:0]      rd_ecc_unc;
    logic [NIF-1:0]      rd_int_err;
    logic [NIF-1:0]      rd_ecc_cor;
    logic [NIF-1:0]      rd_cpu;
    logic [NIF*IDW-1:0]  rd_cpu_id;
    logic [NIF*NCPU-1:0] sts_clr;
    logic [NIF-1:0]      rsp_valid;
    logic [NIF*DW-1:0]   rsp_data;
    logic [NIF-1:0]      rsp_berr;
    logic [NIF-1:0]      rsp_nocache;
    logic [NIF-1:0]      flt_valid;
    logic [NIF*2-1:0]    flt_code;
    logic [NIF*NCPU-1:0] sts_int;

    always #2.5 clk = ~clk;

    frf_top #(.NIF(NIF), .NCPU(NCPU), .DW(DW), .IDW(IDW)) uut (
        .clk(clk), .rst_n(rst_n), .silent_en(silent_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_ecc_unc(rd_ecc_unc), .rd_int_err(rd_int_err),
        .rd_ecc_cor(rd_ecc_cor), .rd_cpu(rd_cpu), .rd_cpu_id(rd_cpu_id),
        .sts_clr(sts_clr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_berr(rsp_berr), .rsp_nocache(rsp_nocache), .flt_valid(flt_valid),
        .flt_code(flt_code), .sts_int(sts_int)
    );

    // Reference model state
    bit          m_valid [NIF];
    logic [31:0] m_data  [NIF];
    bit          m_berr  [NIF];
    bit          m_nocache [NIF];
    bit          m_fv    [NIF];
    int          m_code  [NIF];
    bit          m_sts   [NIF*NCPU];
    string       m_btag  [NIF];

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";

    // Model: what each output must hold after this edge.
    always @(posedge clk) begin
        for (int i = 0; i < NIF; i++) begin
            if (!rst_n) begin
                m_valid[i] = 0; m_data[i] = 0; m_berr[i] = 0; m_nocache[i] = 0;
                m_fv[i] = 0; m_code[i] = 0; m_btag[i] = "R1";
                for (int k = 0; k < NCPU; k++) m_sts[i*NCPU+k] = 0;
            end else begin
                bit v, bad;
                v = rd_valid[i];
                bad = v && (rd_ecc_unc[i] || rd_int_err[i]);
                m_valid[i]   = v;
                m_data[i]    = v ? rd_data[i*DW +: DW] : 32'd0;
                m_nocache[i] = bad;
                if (!bad)              m_berr[i] = 0;
                else if (!rd_cpu[i])   m_berr[i] = 1;
                else                   m_berr[i] = !silent_en[i];
                m_btag[i] = !rd_cpu[i] ? "R3" : (silent_en[i] ? "R5" : "R4");
                m_fv[i] = v && (rd_ecc_unc[i] || rd_int_err[i] || rd_ecc_cor[i]);
                if (!v)                 m_code[i] = 0;
                else if (rd_int_err[i]) m_code[i] = 1;
                else if (rd_ecc_unc[i]) m_code[i] = 2;
                else if (rd_ecc_cor[i]) m_code[i] = 3;
                else                    m_code[i] = 0;
                for (int k = 0; k < NCPU; k++) begin
                    bit set;
                    set = v && rd_cpu[i] && rd_int_err[i] &&
                          (int'(rd_cpu_id[i*IDW +: IDW]) == k);
                    if (set)                        m_sts[i*NCPU+k] = 1;
                    else if (sts_clr[i*NCPU+k])     m_sts[i*NCPU+k] = 0;
                end
            end
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string pick(string dflt);
        return (phase != "") ? phase : dflt;
    endfunction

    // Compare every output against the model after the falling edge.
    task automatic step();
        @(negedge clk);
        for (int i = 0; i < NIF; i++) begin
            chk(pick("R2"), $sformatf("valid[%0d]", i), 64'(rsp_valid[i]), 64'(m_valid[i]));
            chk(pick("R2"), $sformatf("data[%0d]", i), 64'(rsp_data[i*DW +: DW]), 64'(m_data[i]));
            chk(pick(m_btag[i]), $sformatf("berr[%0d]", i), 64'(rsp_berr[i]), 64'(m_berr[i]));
            chk(pick("R6"), $sformatf("nocache[%0d]", i), 64'(rsp_nocache[i]), 64'(m_nocache[i]));
            chk(pick("R7"), $sformatf("fault_v[%0d]", i), 64'(flt_valid[i]), 64'(m_fv[i]));
            chk(pick("R7"), $sformatf("fault_c[%0d]", i), 64'(flt_code[i*2 +: 2]), 64'(m_code[i]));
            for (int k = 0; k < NCPU; k++)
                chk(pick("R8"), $sformatf("sts[%0d]", i*NCPU+k),
                    64'(sts_int[i*NCPU+k]), 64'(m_sts[i*NCPU+k]));
        end
    endtask

    task automatic idle_inputs();
        rd_valid = '0; rd_data = '0; rd_ecc_unc = '0; rd_int_err = '0;
        rd_ecc_cor = '0; rd_cpu = '0; rd_cpu_id = '0; sts_clr = '0;
    endtask

    // Drive one beat on interface i.
    task automatic beat(int i, bit cpu, int id, bit unc, bit ierr, bit cor);
        rd_valid[i] = 1'b1;
        rd_data[i*DW +: DW] = $urandom;
        rd_cpu[i] = cpu;
        rd_cpu_id[i*IDW +: IDW] = IDW'(id);
        rd_ecc_unc[i] = unc;
        rd_int_err[i] = ierr;
        rd_ecc_cor[i] = cor;
    endtask

    initial begin
        rst_n = 1'b0;
        silent_en = '0;
        idle_inputs();
        // R1: outputs are cleared under reset.
        repeat (3) step();
        rst_n = 1'b1;
        phase = "";
        step();

        // R11: flags without valid do nothing.
        phase = "R11";
        rd_ecc_unc = '1; rd_int_err = '1; rd_ecc_cor = '1; rd_cpu = '1;
        repeat (3) step();
        idle_inputs();

        // R10: different silent settings on the two interfaces.
        phase = "R10";
        silent_en = 2'b01;
        beat(0, 1, 0, 1, 0, 0);
        beat(1, 1, 0, 1, 0, 0);
        step();
        idle_inputs();
        step();
        silent_en = 2'b10;
        beat(0, 1, 1, 0, 1, 0);
        beat(1, 1, 1, 0, 1, 0);
        step();
        idle_inputs();
        step();

        // R9: a set and a clear on the same bit in the same cycle; the set wins.
        phase = "R9";
        beat(0, 1, 2, 0, 1, 0);
        sts_clr[2] = 1'b1;
        step();
        idle_inputs();
        step();
        sts_clr = '1;
        step();
        idle_inputs();
        step();

        // Random traffic, covering R2 to R8 with the tags picked from the cause.
        phase = "";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 16 == 0) silent_en = NIF'($urandom);
            idle_inputs();
            for (int i = 0; i < NIF; i++) begin
                if ($urandom % 4 != 0)
                    beat(i, bit'($urandom % 2), int'($urandom % 4),
                         ($urandom % 5 == 0), ($urandom % 6 == 0), ($urandom % 4 == 0));
            end
            if ($urandom % 8 == 0) sts_clr = (NIF*NCPU)'($urandom);
            step();
        end
        idle_inputs();
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5ns * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule